// File: doc/BRIEF.md
# Start-of-Frame Timing Tracker

This block follows USB bus timing on the device side. A token decoder upstream raises a one-cycle strobe with an 11-bit frame number each time a valid start-of-frame token arrives. The block latches that number and counts how many back-to-back start-of-frame tokens carried the same number. On a high-speed bus eight microframes share one frame number, so this repeat count gives the current microframe index.

A sub-frame timer runs alongside. It counts half-microsecond ticks since the most recent start-of-frame, and a parameterized prescaler derives those ticks from the core clock. The prescaler restarts on every start-of-frame, so the timer phase lines up with the token.

All three values are packed into one 32-bit read-only status word. Software or a neighbouring block reads it directly.

Top module: `sof_tracker`

## Requirements
- R1: While reset is high, and on the first cycle after it, the status word reads 0x00000000.
- R2: In the cycle after a strobe, bits 26:16 hold the frame number that came with the strobe.
- R3: Bits 31:28 hold a repeat count. On a strobe whose frame number equals the stored one, and at least one earlier strobe since reset, the count increments. On any other strobe it becomes 0.
- R4: The repeat count saturates at 15 and does not wrap.
- R5: The first strobe after reset sets the repeat count to 0, even when its frame number is 0.
- R6: Bits 11:0 become 0 in the cycle after a strobe. They then increase by one every TICK_DIV clock cycles, so N*TICK_DIV cycles after the strobe edge they read N.
- R7: The timer in bits 11:0 saturates at 0xFFF and holds there until the next strobe.
- R8: Bit 27 and bits 15:12 always read 0.
- R9: Without a strobe, bits 31:16 do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_valid | input | 1 | One-cycle strobe for a decoded start-of-frame token |
| sof_frame | input | 11 | Frame number carried by the token |
| status | output | 32 | Packed status: repeat count, frame number, sub-frame timer |

## Verification
The bench sends eight and then twenty identical frame numbers. A counter that wrapped instead of saturating would read back a small value at the end of that run. It then sweeps all 2048 frame numbers in order, including the wrap from 2047 to 0, which a design comparing numbers loosely would treat as a repeat. A design that treated the reset contents as a real frame would report a repeat of 1 for a first token of frame 0. The bench also lets the timer run past 4095 ticks, where a wrapping counter would fall back to a small value, and it checks the timer's tick phase against the prescaler restart after every token.

// File: rtl/sof_pkg.sv
package sof_pkg;
    localparam int FRAME_W = 11;
    localparam int RPT_W   = 4;
    localparam int TMR_W   = 12;
    localparam int STAT_W  = 32;

    typedef struct packed {
        logic [RPT_W-1:0]   rpt;
        logic               rsv_hi;
        logic [FRAME_W-1:0] frame;
        logic [3:0]         rsv_lo;
        logic [TMR_W-1:0]   timer;
    } sof_status_t;

    function automatic sof_status_t pack_status(
        input logic [RPT_W-1:0]   rpt,
        input logic [FRAME_W-1:0] frame,
        input logic [TMR_W-1:0]   timer
    );
        sof_status_t s;
        s.rpt    = rpt;
        s.rsv_hi = 1'b0;
        s.frame  = frame;
        s.rsv_lo = 4'd0;
        s.timer  = timer;
        return s;
    endfunction
endpackage

// File: rtl/sof_tick_gen.sv
module sof_tick_gen #(
    parameter int TICK_DIV = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sof_frame_track.sv
module sof_frame_track
    import sof_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    output logic [FRAME_W-1:0] frame,
    output logic [RPT_W-1:0]   rpt
);
    logic seen;
    logic same;

    assign same = seen && (sof_frame == frame);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            frame <= '0;
            rpt   <= '0;
        end else if (sof_valid) begin
            seen  <= 1'b1;
            frame <= sof_frame;
            if (!same)          rpt <= '0;
            else if (rpt != '1) rpt <= rpt + 1'b1;
        end
    end
endmodule

// File: rtl/sof_subframe_timer.sv
module sof_subframe_timer
    import sof_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    output logic [TMR_W-1:0] timer
);
    always_ff @(posedge clk) begin
        if (rst || restart)            timer <= '0;
        else if (tick && timer != '1)  timer <= timer + 1'b1;
    end
endmodule

// File: rtl/sof_tracker.sv
module sof_tracker
    import sof_pkg::*;
#(
    parameter int TICK_DIV = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    output logic [STAT_W-1:0]  status
);
    logic               tick;
    logic [FRAME_W-1:0] frame;
    logic [RPT_W-1:0]   rpt;
    logic [TMR_W-1:0]   timer;
    sof_status_t        st;

    sof_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .restart(sof_valid), .tick(tick)
    );

    sof_frame_track u_frame (
        .clk(clk), .rst(rst), .sof_valid(sof_valid), .sof_frame(sof_frame),
        .frame(frame), .rpt(rpt)
    );

    sof_subframe_timer u_timer (
        .clk(clk), .rst(rst), .restart(sof_valid), .tick(tick), .timer(timer)
    );

    always_comb st = pack_status(rpt, frame, timer);
    assign status = st;
endmodule

// File: rtl/sof_tracker_chk.sv
module sof_tracker_chk (
    input logic        clk,
    input logic        rst,
    input logic        sof_valid,
    input logic [10:0] sof_frame,
    input logic [31:0] status
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> status == 32'd0);

    assert_frame_capture_R2: assert property (@(posedge clk) disable iff (rst)
        sof_valid |=> status[26:16] == $past(sof_frame));

    assert_rpt_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (sof_valid && sof_frame != status[26:16]) |=> status[31:28] == 4'd0);

    assert_rpt_hold_max_R4: assert property (@(posedge clk) disable iff (rst)
        (sof_valid && sof_frame == status[26:16] && status[31:28] == 4'hF)
            |=> status[31:28] == 4'hF);

    assert_timer_restart_R6: assert property (@(posedge clk) disable iff (rst)
        sof_valid |=> status[11:0] == 12'd0);

    assert_timer_step_R6: assert property (@(posedge clk) disable iff (rst)
        !sof_valid |=> (status[11:0] == $past(status[11:0]) ||
                        status[11:0] == $past(status[11:0]) + 12'd1));

    assert_timer_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (!sof_valid && status[11:0] == 12'hFFF) |=> status[11:0] == 12'hFFF);

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        status[27] == 1'b0 && status[15:12] == 4'd0);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !sof_valid |=> $stable(status[31:16]));
endmodule

bind sof_tracker sof_tracker_chk u_chk (
    .clk(clk), .rst(rst), .sof_valid(sof_valid),
    .sof_frame(sof_frame), .status(status)
);

// File: tb/tb_sof_tracker.sv
module tb_sof_tracker;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = '0;
    logic [31:0] status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int e_frame = 0;
    int e_rpt   = 0;
    bit e_seen  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    sof_tracker #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .sof_valid(sof_valid),
        .sof_frame(sof_frame), .status(status)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic int exp_timer();
        int t = cyc / DIV;
        return (t > 4095) ? 4095 : t;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " R2 frame"}, int'(status[26:16]), e_frame);
        check({tag, " R3 repeat"}, int'(status[31:28]), e_rpt);
        check({tag, " R6 timer"}, int'(status[11:0]), exp_timer());
        check({tag, " R8 reserved"}, int'({status[27], status[15:12]}), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 status in reset", int'(status), 0);
        rst = 1'b0;
        cyc = 0; e_frame = 0; e_rpt = 0; e_seen = 0;
        check("R1 status after reset", int'(status), 0);
    endtask

    task automatic send(input int f);
        sof_valid = 1'b1;
        sof_frame = 11'(f);
        @(negedge clk);
        sof_valid = 1'b0;
        if (e_seen && f == e_frame) e_rpt = (e_rpt < 15) ? e_rpt + 1 : 15;
        else                        e_rpt = 0;
        e_seen = 1; e_frame = f; cyc = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R5: first strobe after reset with frame 0 must give repeat 0
        send(0);
        check_all("R5 first sof frame 0");
        send(0);
        check_all("R3 second sof frame 0");

        // R3: eight microframes on frame 5
        for (int i = 0; i < 8; i++) begin
            send(5);
            check_all("R3 microframe run");
            idle(2);
        end
        send(6);
        check_all("R3 new frame clears");

        // R6: timer phase, cycle by cycle
        for (int i = 0; i < 40; i++) begin
            idle(1);
            check_all("R6 timer sweep");
        end
        // R6: strobe mid-count restarts prescaler phase
        idle(1);
        send(6);
        for (int i = 0; i < 10; i++) begin
            idle(1);
            check_all("R6 restart phase");
        end

        // R7: saturation
        idle(4096 * DIV + 20);
        check_all("R7 saturated");
        check("R7 timer max", int'(status[11:0]), 4095);
        idle(DIV * 4);
        check("R7 holds", int'(status[11:0]), 4095);
        check_all("R9 idle hold");
        send(7);
        check_all("R6 reload after sat");

        // R4: repeat saturation
        for (int i = 0; i < 20; i++) begin
            send(9);
            check_all("R4 repeat run");
        end
        check("R4 repeat max", int'(status[31:28]), 15);

        // R2/R3: sweep every frame number including wrap to 0
        for (int f = 0; f < 2048; f++) begin
            send(f);
            if (f % 64 == 0) check_all("R2 sweep");
            else check("R2 sweep frame", int'(status[26:16]), f);
        end
        send(0);
        check_all("R3 wrap 2047 to 0 not a repeat");

        // R1/R5: reset mid operation
        send(0);
        idle(5);
        do_reset();
        idle(4);
        check_all("R1 post reset idle");
        send(0);
        check_all("R5 first after second reset");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule